// File: doc/BRIEF.md
# Bit-Addressed Terminal Control Decoder

This block is the single-bit control port of a display terminal controller. The host changes one bit per write. Each write carries a 4-bit bit address, a data bit and a write strobe. A byte-select input gates every write. When it is low, a write to the lower half of the address space loads one bit of an 8-bit character register. A write to the upper half goes to the command decoder. When the byte-select input is high, the block ignores all writes.

The upper half of the address space is banked by a word-select latch that the host itself writes at the top address. The same address can therefore mean one thing in word 0 and another in word 1. A decoded write has one of two effects. It can emit a one-clock active-low command pulse: character strobe, cursor move with its refresh-read request, or keyboard acknowledge. Or it can load a level control latch: keyboard interrupt enable, cursor display, dual intensity, display enable or beep. A sticky previous-state flag records whether word-select was already 1 when the host wrote a 1 to it. The host clears that flag through a dedicated input.

Top module: `ctl_bit_decoder`

## Requirements
- R1: A synchronous reset (rst high) clears the character register, all five control latches, word-select and the previous-state flag to 0, and drives all four pulse outputs high, from the next rising edge.
- R2: While selN is 1, a write changes no latch, no character bit and word-select, and produces no pulse.
- R3: A write of 1 to address 8 in word 0 drives wdStrobeN low for exactly the following cycle. The same write in word 1 produces nothing.
- R4: A write of 1 to address 10 in either word drives cursorMoveN and refreshReadN low together for the following cycle.
- R5: Writes to addresses 9 and 11 change no output in either word.
- R6: A write to address 12 loads the data bit into kbdIntEn in word 0, or into cursorEn in word 1.
- R7: A write to address 13 loads dualIntEn in word 0. In word 1, a write of 1 pulses kbdAckN low for the following cycle.
- R8: A write to address 14 loads dispEn in word 0, or beepEn in word 1.
- R9: A write to address 15 loads the data bit into wordSel in either word.
- R10: prevFlag becomes 1 when a 1 is written to address 15 while wordSel is already 1. After that it stays 1 until prevClrN is sampled low. A low prevClrN clears it, and this clear wins over a set in the same cycle.
- R11: A write to address 0..7 stores the data bit into wrData bit [address]. rdBit always shows wrData[bitAddr[2:0]] combinationally.
- R12: A write of 0 to a pulse address (8, 10, or 13 in word 1) produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | Write request for this cycle |
| bitAddr | input | 4 | Bit address; also selects the read bit |
| dataBit | input | 1 | Serial data bit to write |
| selN | input | 1 | Byte-select enable, active low |
| prevClrN | input | 1 | Clear of previous-state flag, active low |
| wdStrobeN | output | 1 | Character write strobe pulse, active low |
| cursorMoveN | output | 1 | Cursor move pulse, active low |
| refreshReadN | output | 1 | Refresh read request pulse, active low |
| kbdAckN | output | 1 | Keyboard acknowledge pulse, active low |
| kbdIntEn | output | 1 | Keyboard interrupt enable latch |
| cursorEn | output | 1 | Cursor display latch |
| dualIntEn | output | 1 | Dual intensity latch |
| dispEn | output | 1 | Display enable latch |
| beepEn | output | 1 | Beep enable latch |
| wordSel | output | 1 | Word-select latch |
| prevFlag | output | 1 | Sticky previous-state flag |
| wrData | output | 8 | Character register |
| rdBit | output | 1 | Character register bit at bitAddr[2:0] |

## Verification
The bench targets the bank switch. It sends the same address in both words, so a decoder that ignored word-select would load the wrong latch or pulse in the wrong word. It drives two consecutive 1 writes to word-select: a flag that copied word-select directly, instead of its old value, would set on the first write rather than the second. It applies a clear together with a set to check clear priority. It also writes 0 to pulse addresses and writes with selN high, where a design that lost its gating would pulse or change state.

// File: rtl/ctl_bit_pkg.sv
package ctl_bit_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [ADDR_W-1:0] ADR_WDATA_STB = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADR_CUR_MOVE  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] ADR_KBD_CUR   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] ADR_DUAL_ACK  = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] ADR_DISP_BEEP = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ADR_WORD      = ADDR_W'(15);

  typedef struct packed {
    logic             dataWr;
    logic [IDX_W-1:0] idx;
    logic             bitVal;
    logic             ldWord;
    logic             ldKbdInt;
    logic             ldCursor;
    logic             ldDual;
    logic             ldDisp;
    logic             ldBeep;
    logic             pulseWd;
    logic             pulseMove;
    logic             pulseAck;
  } ctlStrobe_t;
endpackage

// File: rtl/ctl_bit_ctrl.sv
module ctl_bit_ctrl
  import ctl_bit_pkg::*;
(
  input  logic              wrStrobe,
  input  logic              selN,
  input  logic [ADDR_W-1:0] bitAddr,
  input  logic              dataBit,
  input  logic              wordSel,
  output ctlStrobe_t        stb
);
  logic dataLatchEnN;
  logic ctrlEnN;

  // byte selector: all enables inactive unless select is low
  always_comb begin
    dataLatchEnN = 1'b1;
    ctrlEnN      = 1'b1;
    if (!selN && wrStrobe) begin
      if (bitAddr[ADDR_W-1]) ctrlEnN = 1'b0;
      else                   dataLatchEnN = 1'b0;
    end
  end

  // banked command decode
  always_comb begin
    stb        = '0;
    stb.idx    = bitAddr[IDX_W-1:0];
    stb.bitVal = dataBit;
    stb.dataWr = !dataLatchEnN;
    if (!ctrlEnN) begin
      case (bitAddr)
        ADR_WDATA_STB: stb.pulseWd   = dataBit & ~wordSel;
        ADR_CUR_MOVE:  stb.pulseMove = dataBit;
        ADR_KBD_CUR: begin
          if (wordSel) stb.ldCursor = 1'b1;
          else         stb.ldKbdInt = 1'b1;
        end
        ADR_DUAL_ACK: begin
          if (wordSel) stb.pulseAck = dataBit;
          else         stb.ldDual   = 1'b1;
        end
        ADR_DISP_BEEP: begin
          if (wordSel) stb.ldBeep = 1'b1;
          else         stb.ldDisp = 1'b1;
        end
        ADR_WORD:      stb.ldWord = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_bit_dpath.sv
module ctl_bit_dpath
  import ctl_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        stb,
  input  logic              prevClrN,
  output logic              wdStrobeN,
  output logic              cursorMoveN,
  output logic              refreshReadN,
  output logic              kbdAckN,
  output logic              kbdIntEn,
  output logic              cursorEn,
  output logic              dualIntEn,
  output logic              dispEn,
  output logic              beepEn,
  output logic              wordSel,
  output logic              prevFlag,
  output logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] bitEn;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitEn
    assign bitEn[i] = stb.dataWr && (stb.idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) wrData <= '0;
    else     wrData <= (wrData & ~bitEn) | ({DATA_W{stb.bitVal}} & bitEn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdStrobeN    <= 1'b1;
      cursorMoveN  <= 1'b1;
      refreshReadN <= 1'b1;
      kbdAckN      <= 1'b1;
    end else begin
      wdStrobeN    <= !stb.pulseWd;
      cursorMoveN  <= !stb.pulseMove;
      refreshReadN <= !stb.pulseMove;
      kbdAckN      <= !stb.pulseAck;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kbdIntEn  <= 1'b0;
      cursorEn  <= 1'b0;
      dualIntEn <= 1'b0;
      dispEn    <= 1'b0;
      beepEn    <= 1'b0;
      wordSel   <= 1'b0;
    end else begin
      if (stb.ldKbdInt) kbdIntEn  <= stb.bitVal;
      if (stb.ldCursor) cursorEn  <= stb.bitVal;
      if (stb.ldDual)   dualIntEn <= stb.bitVal;
      if (stb.ldDisp)   dispEn    <= stb.bitVal;
      if (stb.ldBeep)   beepEn    <= stb.bitVal;
      if (stb.ldWord)   wordSel   <= stb.bitVal;
    end
  end

  // sticky record of word-select already being 1 when a 1 is written to it
  always_ff @(posedge clk) begin
    if (rst || !prevClrN)                          prevFlag <= 1'b0;
    else if (stb.ldWord && stb.bitVal && wordSel)  prevFlag <= 1'b1;
  end
endmodule

// File: rtl/ctl_bit_decoder.sv
module ctl_bit_decoder
  import ctl_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] bitAddr,
  input  logic              dataBit,
  input  logic              selN,
  input  logic              prevClrN,
  output logic              wdStrobeN,
  output logic              cursorMoveN,
  output logic              refreshReadN,
  output logic              kbdAckN,
  output logic              kbdIntEn,
  output logic              cursorEn,
  output logic              dualIntEn,
  output logic              dispEn,
  output logic              beepEn,
  output logic              wordSel,
  output logic              prevFlag,
  output logic [DATA_W-1:0] wrData,
  output logic              rdBit
);
  ctlStrobe_t stb;

  ctl_bit_ctrl u_ctrl (
    .wrStrobe (wrStrobe),
    .selN     (selN),
    .bitAddr  (bitAddr),
    .dataBit  (dataBit),
    .wordSel  (wordSel),
    .stb      (stb)
  );

  ctl_bit_dpath u_dpath (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .prevClrN     (prevClrN),
    .wdStrobeN    (wdStrobeN),
    .cursorMoveN  (cursorMoveN),
    .refreshReadN (refreshReadN),
    .kbdAckN      (kbdAckN),
    .kbdIntEn     (kbdIntEn),
    .cursorEn     (cursorEn),
    .dualIntEn    (dualIntEn),
    .dispEn       (dispEn),
    .beepEn       (beepEn),
    .wordSel      (wordSel),
    .prevFlag     (prevFlag),
    .wrData       (wrData)
  );

  assign rdBit = wrData[bitAddr[IDX_W-1:0]];
endmodule

// File: rtl/ctl_bit_chk.sv
module ctl_bit_chk
  import ctl_bit_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] bitAddr,
  input logic              dataBit,
  input logic              selN,
  input logic              prevClrN,
  input logic              wdStrobeN,
  input logic              cursorMoveN,
  input logic              refreshReadN,
  input logic              kbdAckN,
  input logic              kbdIntEn,
  input logic              cursorEn,
  input logic              dualIntEn,
  input logic              dispEn,
  input logic              beepEn,
  input logic              wordSel,
  input logic              prevFlag,
  input logic [DATA_W-1:0] wrData,
  input logic              rdBit
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (wrData == '0 && !wordSel && !prevFlag && !kbdIntEn && !cursorEn &&
             !dualIntEn && !dispEn && !beepEn && wdStrobeN && cursorMoveN &&
             refreshReadN && kbdAckN));

  a_r2_deselected_idle: assert property (@(posedge clk) disable iff (rst)
    selN |=> ($stable(wrData) && $stable(wordSel) && $stable(kbdIntEn) &&
              $stable(cursorEn) && $stable(dualIntEn) && $stable(dispEn) &&
              $stable(beepEn) && wdStrobeN && cursorMoveN && kbdAckN));

  a_r3_wd_pulse: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !selN && bitAddr == ADR_WDATA_STB && !wordSel && dataBit)
      |=> !wdStrobeN);

  a_r4_move_with_refresh: assert property (@(posedge clk) disable iff (rst)
    !cursorMoveN |-> !refreshReadN);

  a_r9_word_load: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !selN && bitAddr == ADR_WORD) |=> (wordSel == $past(dataBit)));

  a_r10_prev_sticky: assert property (@(posedge clk) disable iff (rst)
    (prevFlag && prevClrN) |=> prevFlag);

  a_r10_prev_clear: assert property (@(posedge clk) disable iff (rst)
    !prevClrN |=> !prevFlag);

  a_r11_char_bit: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !selN && !bitAddr[ADDR_W-1])
      |=> (wrData[$past(bitAddr[IDX_W-1:0])] == $past(dataBit)));
endmodule

bind ctl_bit_decoder ctl_bit_chk u_chk (.*);

// File: tb/sim_ctl_bit_decoder.sv
`timescale 1ns/1ps
module sim_ctl_bit_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrStrobe = 1'b0;
  logic [3:0] bitAddr = 4'd0;
  logic       dataBit = 1'b0;
  logic       selN = 1'b1;
  logic       prevClrN = 1'b1;
  logic wdStrobeN, cursorMoveN, refreshReadN, kbdAckN;
  logic kbdIntEn, cursorEn, dualIntEn, dispEn, beepEn, wordSel, prevFlag, rdBit;
  logic [7:0] wrData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model state
  logic mWd, mMove, mAck, mKbd, mCur, mDual, mDisp, mBeep, mWord, mPrev;
  logic [7:0] mData;

  always #4 clk = ~clk;

  ctl_bit_decoder u0 (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .bitAddr(bitAddr), .dataBit(dataBit),
    .selN(selN), .prevClrN(prevClrN), .wdStrobeN(wdStrobeN), .cursorMoveN(cursorMoveN),
    .refreshReadN(refreshReadN), .kbdAckN(kbdAckN), .kbdIntEn(kbdIntEn),
    .cursorEn(cursorEn), .dualIntEn(dualIntEn), .dispEn(dispEn), .beepEn(beepEn),
    .wordSel(wordSel), .prevFlag(prevFlag), .wrData(wrData), .rdBit(rdBit)
  );

  task automatic modelStep();
    logic hit;
    if (rst) begin
      {mWd, mMove, mAck} = 3'b111;
      {mKbd, mCur, mDual, mDisp, mBeep, mWord, mPrev} = '0;
      mData = '0;
      return;
    end
    hit = wrStrobe && !selN;
    mWd = 1'b1; mMove = 1'b1; mAck = 1'b1;
    if (!prevClrN) mPrev = 1'b0;
    else if (hit && bitAddr == 4'd15 && dataBit && mWord) mPrev = 1'b1;
    if (hit && bitAddr < 4'd8) mData[bitAddr[2:0]] = dataBit;
    if (hit) begin
      case (bitAddr)
        4'd8:  if (!mWord && dataBit) mWd = 1'b0;
        4'd10: if (dataBit) mMove = 1'b0;
        4'd12: if (mWord) mCur = dataBit; else mKbd = dataBit;
        4'd13: if (mWord) begin if (dataBit) mAck = 1'b0; end else mDual = dataBit;
        4'd14: if (mWord) mBeep = dataBit; else mDisp = dataBit;
        4'd15: mWord = dataBit;
        default: ;
      endcase
    end
  endtask

  function automatic logic [19:0] expVec(input logic [3:0] a);
    return {mWd, mMove, mMove, mAck, mKbd, mCur, mDual, mDisp, mBeep, mWord, mPrev,
            mData, mData[a[2:0]]};
  endfunction

  task automatic compare(input string req);
    logic [19:0] act, exp;
    act = {wdStrobeN, cursorMoveN, refreshReadN, kbdAckN, kbdIntEn, cursorEn, dualIntEn,
           dispEn, beepEn, wordSel, prevFlag, wrData, rdBit};
    exp = expVec(bitAddr);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%05h expected=%05h", req, bitAddr, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic d,
                      input logic s, input logic c, input string req);
    @(negedge clk);
    wrStrobe = w; bitAddr = a; dataBit = d; selN = s; prevClrN = c;
    @(posedge clk);
    modelStep();
    #2;
    compare(req);
  endtask

  function automatic string tagFor(input logic [3:0] a, input logic s, input logic c);
    if (!c) return "R10";
    if (s) return "R2";
    case (a)
      4'd8: return "R3";
      4'd9, 4'd11: return "R5";
      4'd10: return "R4";
      4'd12: return "R6";
      4'd13: return "R7";
      4'd14: return "R8";
      4'd15: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1'b1;
    step(1, 4'd15, 1, 0, 1, "R1");
    step(0, 4'd0, 0, 1, 1, "R1");
    rst = 1'b0;
    step(0, 4'd3, 0, 0, 1, "R1");
    // character register
    step(1, 4'd3, 1, 0, 1, "R11");
    step(1, 4'd0, 1, 0, 1, "R11");
    step(1, 4'd7, 1, 0, 1, "R11");
    step(0, 4'd3, 0, 0, 1, "R11");
    step(1, 4'd7, 0, 0, 1, "R11");
    // word 0 decode
    step(1, 4'd8, 1, 0, 1, "R3");
    step(0, 4'd0, 0, 0, 1, "R3");
    step(1, 4'd8, 0, 0, 1, "R12");
    step(1, 4'd9, 1, 0, 1, "R5");
    step(1, 4'd11, 1, 0, 1, "R5");
    step(1, 4'd10, 1, 0, 1, "R4");
    step(1, 4'd10, 0, 0, 1, "R12");
    step(1, 4'd12, 1, 0, 1, "R6");
    step(1, 4'd13, 1, 0, 1, "R7");
    step(1, 4'd14, 1, 0, 1, "R8");
    // deselected writes are ignored
    step(1, 4'd12, 0, 1, 1, "R2");
    step(1, 4'd2, 1, 1, 1, "R2");
    step(1, 4'd15, 1, 1, 1, "R2");
    step(1, 4'd8, 1, 1, 1, "R2");
    // word select and previous-state flag
    step(1, 4'd15, 0, 0, 1, "R9");
    step(1, 4'd15, 1, 0, 1, "R10");
    step(1, 4'd15, 1, 0, 1, "R10");
    // word 1 decode
    step(1, 4'd8, 1, 0, 1, "R3");
    step(1, 4'd12, 1, 0, 1, "R6");
    step(1, 4'd13, 1, 0, 1, "R7");
    step(1, 4'd13, 0, 0, 1, "R12");
    step(1, 4'd14, 1, 0, 1, "R8");
    step(1, 4'd10, 1, 0, 1, "R4");
    step(1, 4'd9, 1, 0, 1, "R5");
    step(1, 4'd15, 0, 0, 1, "R10");
    step(0, 4'd0, 0, 0, 1, "R10");
    step(1, 4'd15, 1, 0, 1, "R9");
    step(1, 4'd15, 1, 0, 0, "R10");
    step(0, 4'd0, 0, 0, 1, "R10");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic s, c;
      a = 4'($urandom_range(0, 15));
      s = ($urandom_range(0, 3) == 0);
      c = ($urandom_range(0, 15) != 0);
      step(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)), s, c, tagFor(a, s, c));
    end
    rst = 1'b1;
    step(1, 4'd12, 1, 0, 1, "R1");
    rst = 1'b0;
    step(0, 4'd5, 0, 0, 1, "R1");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule